// File: doc/BRIEF.md
# Passive STN Panel Timing Generator

This block drives a passive STN display panel from an internal dot clock of period T. It produces a serial shift clock, an 8-bit pixel bus, a line pulse, a first-line frame marker and an AC-drive phase signal. Pixel bytes arrive on a ready/valid stream. The block takes one byte for every shift-clock period. Each line is a fixed number of bytes, followed by a line pulse of programmable width. A frame is a fixed number of lines.

The panel-type input sets the shift-clock period: four dot clocks for a monochrome panel, two for a colour panel. The screen-mode input sets the granularity of the line pulse: 8T steps for a single screen, 16T steps for a dual screen. The frame marker and the AC-drive phase are both placed around the falling edge of the line pulse. The panel can then latch them cleanly.

The configuration inputs are plain levels. They are meant to be set while the block is held in reset.

Top module: `stn_panel_timer`

## Requirements
- R1: The shift clock `sck` has a period of 4 dot clocks when `cfg_color`=0 and 2 dot clocks when `cfg_color`=1. Each high phase lasts exactly half that period, and so does each low phase between two rising edges of the same line.
- R2: `pix_ready` is high for exactly one cycle per byte slot: the first cycle of the slot, while `sck` is low. A byte accepted in that cycle appears on `lcd_data` in the next cycle, together with the rising edge of `sck`. It is unchanged at the following falling edge of `sck`.
- R3: Between two line pulses, `sck` rises exactly `cfg_bytes_per_line` times. A value of 0 is treated as 1.
- R4: The line pulse `lc` stays high for (`cfg_lc_width`+1)×8 dot clocks when `cfg_dual`=0, and for (`cfg_lc_width`+1)×16 when `cfg_dual`=1. `cfg_lc_width` is a 4-bit count.
- R5: `sck` is low for every cycle in which `lc` is high.
- R6: `frm` is high for the whole line pulse that ends the first line of each frame, and for the one cycle after that pulse falls. `frm` is low at all other times. A frame is `cfg_lines` lines long, and the first line after reset is the first line of a frame.
- R7: `m` changes exactly once per frame. The change comes in the cycle after the falling edge of the line pulse that ends the last line of the frame, and `m` is steady at all other times.
- R8: If `pix_valid` is low when a slot starts, `lcd_data` keeps its previous value and `underrun` is high for exactly the next cycle. No byte is consumed, and the slot still produces its shift-clock pulse.
- R9: While `rst_n` is low, `sck`, `lc`, `frm`, `m`, `underrun` and `lcd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, period T |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_color | input | 1 | 1 = colour panel (2T shift clock), 0 = monochrome (4T) |
| cfg_dual | input | 1 | 1 = dual-screen (16T pulse steps), 0 = single (8T steps) |
| cfg_lc_width | input | 4 | Line-pulse width count N, giving N+1 steps |
| cfg_bytes_per_line | input | 10 | Bytes shifted per line |
| cfg_lines | input | 10 | Lines per frame |
| pix_data | input | 8 | Incoming pixel byte |
| pix_valid | input | 1 | Pixel byte valid |
| pix_ready | output | 1 | Block takes the byte in this cycle |
| sck | output | 1 | Panel shift clock |
| lcd_data | output | 8 | Pixel bus to the panel |
| lc | output | 1 | Line pulse |
| frm | output | 1 | First-line frame marker |
| m | output | 1 | AC-drive phase |
| underrun | output | 1 | One-cycle flag: a slot started without a byte |

## Verification
The properties assume that the configuration inputs hold still whenever reset is released. This matters because the slot length, pulse length and frame length are decoded from them on every cycle. The properties also assume that the byte and line counts are at least one. The bench changes the configuration only while `rst_n` is low, and it draws the byte and line counts from ranges that start at one. `pix_valid` and `pix_data` are driven freely, including in cycles where `pix_ready` is low. This shows that the block takes nothing outside its slot starts.

// File: rtl/stn_pkg.sv
package stn_pkg;
    // dot clocks per byte slot for each panel kind
    localparam int MONO_SLOT    = 4;
    localparam int COLOR_SLOT   = 2;
    // log2 of the line-pulse step in dot clocks
    localparam int SINGLE_SHIFT = 3;
    localparam int DUAL_SHIFT   = 4;
endpackage

// File: rtl/stn_shift_unit.sv
module stn_shift_unit
    import stn_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BPL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              color_i,
    input  logic              active_i,
    input  logic [BPL_W-1:0]  bytes_i,
    input  logic [DATA_W-1:0] pix_data_i,
    input  logic              pix_valid_i,
    output logic              pix_ready_o,
    output logic              sck_o,
    output logic [DATA_W-1:0] data_o,
    output logic              underrun_o,
    output logic              row_end_o
);
    localparam int PH_W = $clog2(MONO_SLOT);

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [BPL_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic              under;
    } shift_st_t;

    shift_st_t       st_q, st_d;
    logic [PH_W-1:0] last_phase;
    logic [PH_W-1:0] high_end;
    logic [BPL_W-1:0] last_idx;
    logic            slot_start;
    logic            line_last;

    always_comb begin
        last_phase = color_i ? PH_W'(COLOR_SLOT - 1) : PH_W'(MONO_SLOT - 1);
        high_end   = color_i ? PH_W'(COLOR_SLOT / 2) : PH_W'(MONO_SLOT / 2);
        last_idx   = (bytes_i == '0) ? '0 : bytes_i - 1'b1;
        slot_start = active_i && (st_q.phase == '0);
        line_last  = active_i && (st_q.phase == last_phase) && (st_q.idx == last_idx);

        st_d       = st_q;
        st_d.under = 1'b0;
        if (active_i) begin
            if (st_q.phase == last_phase) begin
                st_d.phase = '0;
                st_d.idx   = line_last ? '0 : st_q.idx + 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
            if (slot_start) begin
                if (pix_valid_i) st_d.data  = pix_data_i;
                else             st_d.under = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // high from the cycle after the slot start through half the slot
    assign sck_o       = active_i && (st_q.phase != '0) && (st_q.phase <= high_end);
    assign pix_ready_o = slot_start;
    assign data_o      = st_q.data;
    assign underrun_o  = st_q.under;
    assign row_end_o   = line_last;

    // R2: pixel bus never moves on the shift-clock falling edge
    a_r2_data_steady_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_o) |-> $stable(data_o));
    // R2: a byte is only taken while the shift clock is low
    a_r2_ready_with_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready_o |-> !sck_o);
    // R8: underrun flag lasts a single cycle
    a_r8_underrun_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> !underrun_o);
    // R8: bus keeps its old value when a slot found no byte
    a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> $stable(data_o));
endmodule

// File: rtl/stn_line_seq.sv
module stn_line_seq
    import stn_pkg::*;
#(
    parameter int WID_W   = 4,
    parameter int LINES_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dual_i,
    input  logic [WID_W-1:0]   width_i,
    input  logic [LINES_W-1:0] lines_i,
    input  logic               row_end_i,
    output logic               active_o,
    output logic               lc_o,
    output logic               frm_o,
    output logic               m_o
);
    localparam int CNT_W = WID_W + DUAL_SHIFT + 1;

    typedef struct packed {
        logic               pulse;
        logic [CNT_W-1:0]   cnt;
        logic [LINES_W-1:0] line;
        logic               frm_hold;
        logic               flip_pend;
        logic               m;
    } seq_st_t;

    seq_st_t            st_q, st_d;
    logic [CNT_W-1:0]   lc_len;
    logic [LINES_W-1:0] last_line;

    always_comb begin
        lc_len    = (CNT_W'(width_i) + CNT_W'(1)) << (dual_i ? DUAL_SHIFT : SINGLE_SHIFT);
        last_line = (lines_i == '0) ? '0 : lines_i - 1'b1;

        st_d           = st_q;
        st_d.frm_hold  = 1'b0;
        st_d.flip_pend = 1'b0;
        if (st_q.flip_pend) st_d.m = ~st_q.m;

        if (!st_q.pulse) begin
            if (row_end_i) begin
                st_d.pulse = 1'b1;
                st_d.cnt   = '0;
            end
        end else if (st_q.cnt == lc_len - 1'b1) begin
            st_d.pulse     = 1'b0;
            st_d.frm_hold  = (st_q.line == '0);
            st_d.flip_pend = (st_q.line == last_line);
            st_d.line      = (st_q.line == last_line) ? '0 : st_q.line + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = !st_q.pulse;
    assign lc_o     = st_q.pulse;
    assign frm_o    = (st_q.pulse && st_q.line == '0) || st_q.frm_hold;
    assign m_o      = st_q.m;

    // R4: pulse counter stays inside the programmed width
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lc_o |-> (st_q.cnt < lc_len));
    // R6: frame marker only during a line pulse or right after it
    a_r6_frm_beside_lc: assert property (@(posedge clk) disable iff (!rst_n)
        frm_o |-> (lc_o || $past(lc_o)));
    // R7: AC phase moves only one cycle after the line pulse fell
    a_r7_m_after_lc_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(m_o) |-> (!lc_o && !$past(lc_o) && $past(lc_o, 2)));
endmodule

// File: rtl/stn_panel_timer.sv
module stn_panel_timer #(
    parameter int DATA_W  = 8,
    parameter int BPL_W   = 10,
    parameter int LINES_W = 10,
    parameter int WID_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_color,
    input  logic               cfg_dual,
    input  logic [WID_W-1:0]   cfg_lc_width,
    input  logic [BPL_W-1:0]   cfg_bytes_per_line,
    input  logic [LINES_W-1:0] cfg_lines,
    input  logic [DATA_W-1:0]  pix_data,
    input  logic               pix_valid,
    output logic               pix_ready,
    output logic               sck,
    output logic [DATA_W-1:0]  lcd_data,
    output logic               lc,
    output logic               frm,
    output logic               m,
    output logic               underrun
);
    logic active;
    logic row_end;

    stn_shift_unit #(.DATA_W(DATA_W), .BPL_W(BPL_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .color_i     (cfg_color),
        .active_i    (active),
        .bytes_i     (cfg_bytes_per_line),
        .pix_data_i  (pix_data),
        .pix_valid_i (pix_valid),
        .pix_ready_o (pix_ready),
        .sck_o       (sck),
        .data_o      (lcd_data),
        .underrun_o  (underrun),
        .row_end_o   (row_end)
    );

    stn_line_seq #(.WID_W(WID_W), .LINES_W(LINES_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dual_i    (cfg_dual),
        .width_i   (cfg_lc_width),
        .lines_i   (cfg_lines),
        .row_end_i (row_end),
        .active_o  (active),
        .lc_o      (lc),
        .frm_o     (frm),
        .m_o       (m)
    );

    // R5: no shifting while the line pulse is high
    a_r5_sck_quiet_in_lc: assert property (@(posedge clk) disable iff (!rst_n)
        lc |-> !sck);
endmodule

// File: tb/tb_stn_panel_timer.sv
module tb_stn_panel_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_color = 1'b0, cfg_dual = 1'b0;
    logic [3:0] cfg_lc_width = '0;
    logic [9:0] cfg_bytes_per_line = 10'd1, cfg_lines = 10'd1;
    logic [7:0] pix_data = '0;
    logic       pix_valid = 1'b0;
    logic       pix_ready, sck, lc, frm, m, underrun;
    logic [7:0] lcd_data;

    stn_panel_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_color(cfg_color), .cfg_dual(cfg_dual),
        .cfg_lc_width(cfg_lc_width), .cfg_bytes_per_line(cfg_bytes_per_line),
        .cfg_lines(cfg_lines), .pix_data(pix_data), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .sck(sck), .lcd_data(lcd_data), .lc(lc),
        .frm(frm), .m(m), .underrun(underrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run = 0, n_fail = 0, cyc = 0;
    int P, W, bpl, nlines, rate;
    bit mon_on = 0;
    bit prev_sck, prev_lc, prev_m, rise_seen, exp_m, m_due, acc_pend, und_pend;
    int hi_run, lc_run, last_rise, rises, readies, line_pos, lc_count;
    logic [7:0] exp_data, acc_byte;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            check(0, "watchdog expired", cyc, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // monitor and stimulus share one negedge process
    always @(negedge clk) begin
        if (mon_on) begin
            bit exp_frm;
            if (acc_pend) exp_data = acc_byte;
            if (und_pend || underrun)
                check(underrun == und_pend, "R8 underrun flag", int'(underrun), int'(und_pend));
            if (und_pend)
                check(lcd_data == exp_data, "R8 data held", lcd_data, exp_data);
            if (m_due) begin exp_m = ~exp_m; m_due = 0; end
            if (m != prev_m || m != exp_m)
                check(m == exp_m, "R7 M phase", int'(m), int'(exp_m));
            if (lc && sck) check(0, "R5 sck high during LC", 1, 0);
            if (pix_ready) readies++;
            if (sck && !prev_sck) begin
                if (rise_seen) check(cyc - last_rise == P, "R1 sck period", cyc - last_rise, P);
                rise_seen = 1; last_rise = cyc; rises++;
            end
            if (sck) hi_run++;
            if (!sck && prev_sck) begin
                check(hi_run == P/2, "R1 sck high time", hi_run, P/2);
                hi_run = 0;
                check(lcd_data == exp_data, "R2 data at sck fall", lcd_data, exp_data);
            end
            exp_frm = (lc && line_pos == 0) || (!lc && prev_lc && line_pos == 0);
            if (frm || exp_frm) check(frm == exp_frm, "R6 FRM", int'(frm), int'(exp_frm));
            if (lc && !prev_lc) begin
                check(rises == bpl, "R3 sck rises per line", rises, bpl);
                check(readies == bpl, "R2 ready slots per line", readies, bpl);
                rises = 0; readies = 0; rise_seen = 0; lc_count++;
            end
            if (lc) lc_run++;
            if (!lc && prev_lc) begin
                check(lc_run == W, "R4 LC width", lc_run, W);
                lc_run = 0;
                if (line_pos == nlines - 1) m_due = 1;
                line_pos = (line_pos + 1) % nlines;
            end
            acc_pend = 0; und_pend = 0;
            if (pix_ready) begin
                pix_valid = (int'($urandom % 100) < rate);
                pix_data  = 8'($urandom);
                if (pix_valid) begin acc_pend = 1; acc_byte = pix_data; end
                else und_pend = 1;
            end else begin
                pix_valid = 1'($urandom % 2);
                pix_data  = 8'($urandom);
            end
            prev_sck = sck; prev_lc = lc; prev_m = m;
        end
    end

    task automatic run_test(input bit col, input bit dual, input int n, input int b,
                            input int l, input int r);
        int cycles, line_len, exp_lines;
        mon_on = 0; rst_n = 0; pix_valid = 0;
        cfg_color = col; cfg_dual = dual; cfg_lc_width = 4'(n);
        cfg_bytes_per_line = 10'(b); cfg_lines = 10'(l);
        P = col ? 2 : 4; W = (n + 1) * (dual ? 16 : 8); bpl = b; nlines = l; rate = r;
        repeat (3) @(negedge clk);
        #1;
        // R9: all panel outputs quiet in reset
        check({sck, lc, frm, m, underrun} == 5'b0 && lcd_data == 8'd0, "R9 reset state",
              int'({sck, lc, frm, m, underrun, lcd_data}), 0);
        prev_sck = 0; prev_lc = 0; prev_m = 0; rise_seen = 0; exp_m = 0; m_due = 0;
        hi_run = 0; lc_run = 0; last_rise = 0; rises = 0; readies = 1; line_pos = 0;
        lc_count = 0; exp_data = 8'd0;
        pix_data = 8'($urandom); pix_valid = 1;
        acc_pend = 1; acc_byte = pix_data; und_pend = 0;
        rst_n = 1; mon_on = 1;
        line_len = bpl * P + W;
        cycles = 3 * nlines * line_len + 10;
        repeat (cycles) @(posedge clk);
        mon_on = 0;
        exp_lines = cycles / line_len;
        // R3: line pulses keep coming at the expected rate
        check(lc_count >= exp_lines - 1 && lc_count <= exp_lines + 1, "R3 line count",
              lc_count, exp_lines);
    endtask

    initial begin
        void'($urandom(32'd2024));
        run_test(0, 0, 0, 1, 1, 100);
        run_test(1, 1, 15, 3, 2, 100);
        run_test(0, 1, 2, 5, 3, 60);
        run_test(1, 0, 0, 1, 3, 0);
        run_test(1, 0, 7, 16, 2, 100);
        run_test(0, 0, 15, 2, 1, 80);
        for (int k = 0; k < 8; k++) begin
            run_test(1'($urandom % 2), 1'($urandom % 2), int'($urandom % 16),
                     1 + int'($urandom % 12), 1 + int'($urandom % 4),
                     40 + int'($urandom % 61));
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule